// File: doc/BRIEF.md
# SPI Bus Word Monitor

This block watches a four-wire SPI bus (serial clock, chip select, controller-to-peripheral data and peripheral-to-controller data) without ever driving it. All four bus lines are brought into the system clock domain through a two-stage synchronizer and oversampled. The system clock must run at least four times faster than the serial clock. A serial clock edge is recognised only when the synchronized clock level differs from the previously seen level. The clock history starts at level 1 after reset.

On every sampling edge, one bit of each data line is shifted into its own word register at the same bit position. The sampling edge is chosen by the configured clock polarity and phase. When the configured number of bits has been gathered, the block emits a one-cycle strobe. With the strobe come both data words, a framing warning and a running word count. The warning is raised when chip select was inactive at the first bit of the word. Chip-select polarity, bit order and word length are configuration inputs. They are held steady while the monitor is out of reset.

Top module: `spi_bus_monitor`

## Requirements
- R1: With `cfg_cpol == cfg_cpha`, bits are taken on a rising serial clock edge. Otherwise they are taken on a falling edge.
- R2: A sample whose serial clock level equals the previous level is not an edge. The remembered level is 1 after reset, so in the falling-edge modes a clock line that sits low right after reset yields one bit.
- R3: Each sampling edge captures `bus_mosi` into `word_mosi` and `bus_miso` into `word_miso` at the same bit position.
- R4: With `cfg_lsb_first = 0`, bit number n of a word (n counted from 0 in arrival order) lands at position `len-1-n`. With `cfg_lsb_first = 1`, it lands at position n.
- R5: The word length is `cfg_word_len` when it lies in 1..MAX_BITS (32). A value of 0, or any value above 32, means 32. A word is complete when that many bits have been taken. Output bits at and above the length read 0.
- R6: With `cfg_cs_high = 0`, chip select is active when `bus_cs` is 0. With `cfg_cs_high = 1`, it is active when `bus_cs` is 1.
- R7: `word_warn` is 1 with a completed word exactly when chip select was inactive at that word's first bit. Inactivity at later bits does not set it. The flag is cleared for the following word.
- R8: `word_count` is 0 after reset and rises by one with every completed word.
- R9: `word_valid` is high for exactly one system clock per word. `word_mosi`, `word_miso`, `word_warn` and `word_count` hold their values until the next word completes.
- R10: While and right after reset, `word_valid`, both words, `word_warn` and `word_count` are 0.
- R11: The word-completing bit is reported with `word_valid` high after the third rising system clock edge that follows the change of the bus pins. It is not high after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Clock polarity setting |
| cfg_cpha | input | 1 | Clock phase setting |
| cfg_cs_high | input | 1 | 1: chip select active high, 0: active low |
| cfg_lsb_first | input | 1 | 1: first bit is bit 0, 0: first bit is the top bit |
| cfg_word_len | input | 6 | Bits per word, 0 or above 32 means 32 |
| bus_sclk | input | 1 | Observed serial clock |
| bus_cs | input | 1 | Observed chip select |
| bus_mosi | input | 1 | Observed controller-to-peripheral data |
| bus_miso | input | 1 | Observed peripheral-to-controller data |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_mosi | output | 32 | Captured controller-to-peripheral word |
| word_miso | output | 32 | Captured peripheral-to-controller word |
| word_warn | output | 1 | Chip select was inactive at the word's first bit |
| word_count | output | 16 | Number of words completed since reset |

## Verification
A bit counter that slips shows at once as a strobe arriving a bit early or late. After that, every later word is misaligned, so the fault is visible at the first word boundary after it occurs. A wrong bit position or a mixed-up edge selection corrupts the very next reported word. A stale warning or data accumulator shows in the word that follows. The bench mirrors the pin-to-strobe latency and compares all outputs every cycle, so each of these faults is caught in the cycle it reaches the ports.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    // Serial clock level that marks a sampling edge for a polarity/phase pair
    function automatic logic sample_level(input logic cpol, input logic cpha);
        return (cpol == cpha);
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = din;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage1 <= RST_VAL;
            st_q.stage2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage2;

    // R11: second stage follows first stage one cycle later
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dout == $past(st_q.stage1));

endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge
    import spi_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    output logic sample_en
);

    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t st_d, st_q;
    logic  changed;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sclk_s;
        changed   = (sclk_s != st_q.prev);
        sample_en = changed && (sclk_s == sample_level(cfg_cpol, cfg_cpha));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= 1'b1;
        else        st_q      <= st_d;
    end

    // R2: two sampling edges can never be adjacent
    edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> !sample_en);

endmodule

// File: rtl/spi_mon_capture.sv
module spi_mon_capture #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = $clog2(MAX_BITS + 1),
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                mosi_s,
    input  logic                miso_s,
    input  logic                cs_active,
    input  logic                lsb_first,
    input  logic [LEN_W-1:0]    len_eff,
    output logic                out_valid,
    output logic [MAX_BITS-1:0] out_mosi,
    output logic [MAX_BITS-1:0] out_miso,
    output logic                out_warn,
    output logic [CNT_W-1:0]    out_count
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0]    cnt;
        logic [MAX_BITS-1:0] acc_mosi;
        logic [MAX_BITS-1:0] acc_miso;
        logic                warn_acc;
        logic                valid;
        logic [MAX_BITS-1:0] rep_mosi;
        logic [MAX_BITS-1:0] rep_miso;
        logic                rep_warn;
        logic [CNT_W-1:0]    rep_count;
    } cap_t;

    cap_t                st_d, st_q;
    logic [LEN_W-1:0]    pos;
    logic [LEN_W-1:0]    cnt_next;
    logic [MAX_BITS-1:0] bit_sel;
    logic [MAX_BITS-1:0] mosi_n, miso_n;
    logic                warn_n;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        pos        = lsb_first ? st_q.cnt : (len_eff - ONE - st_q.cnt);
        bit_sel    = MAX_BITS'(1) << pos;
        cnt_next   = st_q.cnt + ONE;
        mosi_n     = st_q.acc_mosi | (mosi_s ? bit_sel : '0);
        miso_n     = st_q.acc_miso | (miso_s ? bit_sel : '0);
        warn_n     = st_q.warn_acc | ((st_q.cnt == '0) && !cs_active);
        if (sample_en) begin
            if (cnt_next == len_eff) begin
                st_d.valid     = 1'b1;
                st_d.rep_mosi  = mosi_n;
                st_d.rep_miso  = miso_n;
                st_d.rep_warn  = warn_n;
                st_d.rep_count = st_q.rep_count + CNT_W'(1);
                st_d.cnt       = '0;
                st_d.acc_mosi  = '0;
                st_d.acc_miso  = '0;
                st_d.warn_acc  = 1'b0;
            end else begin
                st_d.cnt       = cnt_next;
                st_d.acc_mosi  = mosi_n;
                st_d.acc_miso  = miso_n;
                st_d.warn_acc  = warn_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_mosi  = st_q.rep_mosi;
    assign out_miso  = st_q.rep_miso;
    assign out_warn  = st_q.rep_warn;
    assign out_count = st_q.rep_count;

    // R5
    bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < len_eff);

    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_mosi) && $stable(out_miso) && $stable(out_warn) && $stable(out_count)));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count == $past(out_count) + CNT_W'(1));

endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = $clog2(MAX_BITS + 1),
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_cs_high,
    input  logic                cfg_lsb_first,
    input  logic [LEN_W-1:0]    cfg_word_len,
    input  logic                bus_sclk,
    input  logic                bus_cs,
    input  logic                bus_mosi,
    input  logic                bus_miso,
    output logic                word_valid,
    output logic [MAX_BITS-1:0] word_mosi,
    output logic [MAX_BITS-1:0] word_miso,
    output logic                word_warn,
    output logic [CNT_W-1:0]    word_count
);

    localparam int               NLINES  = 4;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BITS);
    // line order: [3] serial clock, [2] chip select, [1] mosi, [0] miso
    localparam logic [NLINES-1:0] LINE_RST = 4'b1000;

    logic [NLINES-1:0]   lines_raw, lines_s;
    logic                sample_en;
    logic                cs_active;
    logic [LEN_W-1:0]    len_eff;
    logic [MAX_BITS-1:0] len_mask;

    assign lines_raw = {bus_sclk, bus_cs, bus_mosi, bus_miso};

    spi_mon_sync #(.WIDTH(NLINES), .RST_VAL(LINE_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lines_raw),
        .dout (lines_s)
    );

    spi_mon_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[3]),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .sample_en(sample_en)
    );

    always_comb begin
        len_eff   = ((cfg_word_len == '0) || (cfg_word_len > MAX_LEN)) ? MAX_LEN : cfg_word_len;
        cs_active = (lines_s[2] == cfg_cs_high);
    end

    spi_mon_capture #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .mosi_s   (lines_s[1]),
        .miso_s   (lines_s[0]),
        .cs_active(cs_active),
        .lsb_first(cfg_lsb_first),
        .len_eff  (len_eff),
        .out_valid(word_valid),
        .out_mosi (word_mosi),
        .out_miso (word_miso),
        .out_warn (word_warn),
        .out_count(word_count)
    );

    always_comb begin
        for (int i = 0; i < MAX_BITS; i++) begin
            len_mask[i] = (LEN_W'(i) < len_eff);
        end
    end

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (((word_mosi | word_miso) & ~len_mask) == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!word_valid && word_count == '0 && !word_warn));

endmodule

// File: tb/sim_spi_bus_monitor.sv
module sim_spi_bus_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SPI   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_high = 1'b0, cfg_lsb_first = 1'b0;
    logic [5:0]  cfg_word_len = 6'd8;
    logic        bus_sclk = 1'b1, bus_cs = 1'b1, bus_mosi = 1'b0, bus_miso = 1'b0;
    logic        word_valid, word_warn;
    logic [31:0] word_mosi, word_miso;
    logic [15:0] word_count;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    finished = 0;
    string cur_req = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bus_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cs_high(cfg_cs_high),
        .cfg_lsb_first(cfg_lsb_first), .cfg_word_len(cfg_word_len),
        .bus_sclk(bus_sclk), .bus_cs(bus_cs), .bus_mosi(bus_mosi), .bus_miso(bus_miso),
        .word_valid(word_valid), .word_mosi(word_mosi), .word_miso(word_miso),
        .word_warn(word_warn), .word_count(word_count)
    );

    // ---------------- behavioural reference model ----------------
    logic [3:0]  h1, h2, h3;
    int          m_cnt;
    logic [31:0] m_amo, m_ami, m_mo, m_mi;
    bit          m_wacc, m_valid, m_warn;
    int          m_count;

    function automatic int eff_len();
        return (cfg_word_len == 0 || cfg_word_len > 32) ? 32 : int'(cfg_word_len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 4'b1000; h2 = 4'b1000; h3 = 4'b1000;
            m_cnt = 0; m_amo = 0; m_ami = 0; m_wacc = 0;
            m_valid = 0; m_mo = 0; m_mi = 0; m_warn = 0; m_count = 0;
        end else begin
            m_valid = 0;
            if (h2[3] != h3[3] && h2[3] == (cfg_cpol == cfg_cpha)) begin
                int pos;
                pos = cfg_lsb_first ? m_cnt : eff_len() - 1 - m_cnt;
                if (m_cnt == 0) m_wacc = (h2[2] != cfg_cs_high);
                if (h2[1]) m_amo[pos] = 1'b1;
                if (h2[0]) m_ami[pos] = 1'b1;
                m_cnt++;
                if (m_cnt == eff_len()) begin
                    m_valid = 1; m_mo = m_amo; m_mi = m_ami; m_warn = m_wacc;
                    m_count = (m_count + 1) % 65536;
                    m_cnt = 0; m_amo = 0; m_ami = 0; m_wacc = 0;
                end
            end
            h3 = h2; h2 = h1; h1 = {bus_sclk, bus_cs, bus_mosi, bus_miso};
        end
    end

    logic [31:0] last_mo, last_mi;
    bit          last_warn;
    int          last_count;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (word_valid !== m_valid || word_mosi !== m_mo || word_miso !== m_mi ||
                word_warn !== m_warn || int'(word_count) != m_count) begin
                bad++;
                $display("FAIL %s cycle: actual v=%0b mo=%h mi=%h w=%0b c=%0d expected v=%0b mo=%h mi=%h w=%0b c=%0d",
                         cur_req, word_valid, word_mosi, word_miso, word_warn, word_count,
                         m_valid, m_mo, m_mi, m_warn, m_count);
            end
            if (word_valid) begin
                last_mo = word_mosi; last_mi = word_miso;
                last_warn = word_warn; last_count = int'(word_count);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cs(input bit active);
        bus_cs = active ? cfg_cs_high : ~cfg_cs_high;
    endtask

    task automatic apply_reset(input bit cpol, input bit cpha, input bit lsb,
                               input bit csh, input logic [5:0] len);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_cs_high = csh; cfg_word_len = len;
        bus_sclk = 1'b1; bus_mosi = 1'b0; bus_miso = 1'b0;
        set_cs(1'b0);
        wait_cycles(3);
        rst_n = 1'b1;
    endtask

    task automatic go_idle();
        bus_sclk = cfg_cpol;
        wait_cycles(6);
    endtask

    // Sends n bits; wire bit i is word bit (lsb ? i : n-1-i). cs goes inactive from bit cs_off on.
    task automatic send_bits(input logic [31:0] mo, input logic [31:0] mi, input int n,
                             input int cs_off);
        set_cs(cs_off != 0);
        wait_cycles(2);
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : n - 1 - i;
            if (i == cs_off) set_cs(1'b0);
            if (!cfg_cpha) begin
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                wait_cycles(HALF_SPI);
                bus_sclk = ~cfg_cpol;
                wait_cycles(HALF_SPI);
                bus_sclk = cfg_cpol;
            end else begin
                bus_sclk = ~cfg_cpol;
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                wait_cycles(HALF_SPI);
                bus_sclk = cfg_cpol;
                wait_cycles(HALF_SPI);
            end
        end
        wait_cycles(HALF_SPI);
        set_cs(1'b0);
        wait_cycles(4);
    endtask

    task automatic expect_word(input string req, input logic [31:0] mo, input logic [31:0] mi,
                               input bit w, input int c);
        check({req, " mosi"}, last_mo == mo, last_mo, mo);
        check({req, " miso"}, last_mi == mi, last_mi, mi);
        check({req, " warn"}, last_warn == w, last_warn, w);
        check({req, " count"}, last_count == c, last_count, c);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        apply_reset(1'b0, 1'b0, 1'b0, 1'b0, 6'd8);
        @(negedge clk);
        // R10
        check("R10 reset outputs", !word_valid && word_mosi == 0 && word_miso == 0 &&
              !word_warn && word_count == 0, {word_valid, word_count}, 0);
        go_idle();

        cur_req = "R1 R3";
        send_bits(32'hA5, 32'h3C, 8, 99);
        expect_word("R1 R3 mode0", 32'hA5, 32'h3C, 0, 1);
        cur_req = "R8";
        send_bits(32'h0F, 32'hF0, 8, 99);
        expect_word("R8 second word", 32'h0F, 32'hF0, 0, 2);

        cur_req = "R7";
        send_bits(32'h81, 32'h7E, 8, 0);
        expect_word("R7 cs inactive at first bit", 32'h81, 32'h7E, 1, 3);
        send_bits(32'h42, 32'h24, 8, 99);
        expect_word("R7 flag cleared next word", 32'h42, 32'h24, 0, 4);
        send_bits(32'hC3, 32'h5A, 8, 3);
        expect_word("R7 late inactivity ignored", 32'hC3, 32'h5A, 0, 5);

        cur_req = "R9";
        wait_cycles(20);
        check("R9 hold after strobe", !word_valid && word_mosi == 32'hC3 && word_count == 5,
              word_mosi, 32'hC3);

        cur_req = "R1";
        apply_reset(1'b1, 1'b1, 1'b0, 1'b0, 6'd8);
        go_idle();
        send_bits(32'h5E, 32'hE5, 8, 99);
        expect_word("R1 mode3", 32'h5E, 32'hE5, 0, 1);
        apply_reset(1'b1, 1'b0, 1'b0, 1'b0, 6'd8);
        go_idle();
        send_bits(32'h93, 32'h6C, 8, 99);
        expect_word("R1 mode2", 32'h93, 32'h6C, 0, 1);

        // R2: mode 1, line low after reset is a falling edge from the reset history of 1
        cur_req = "R2";
        apply_reset(1'b0, 1'b1, 1'b0, 1'b0, 6'd8);
        set_cs(1'b1);
        bus_mosi = 1'b1; bus_miso = 1'b0;
        wait_cycles(2);
        bus_sclk = 1'b0;
        wait_cycles(HALF_SPI);
        send_bits(32'h2B, 32'h55, 7, 99);
        expect_word("R2 reset history edge", 32'hAB, 32'h55, 0, 1);

        cur_req = "R4";
        apply_reset(1'b0, 1'b0, 1'b1, 1'b0, 6'd8);
        go_idle();
        send_bits(32'h96, 32'h1E, 8, 99);
        expect_word("R4 lsb first", 32'h96, 32'h1E, 0, 1);

        cur_req = "R5";
        apply_reset(1'b0, 1'b0, 1'b0, 1'b0, 6'd5);
        go_idle();
        send_bits(32'h12, 32'h0D, 5, 99);
        expect_word("R5 five bits", 32'h12, 32'h0D, 0, 1);
        apply_reset(1'b0, 1'b0, 1'b0, 1'b0, 6'd0);
        go_idle();
        send_bits(32'hDEADBEEF, 32'h01234567, 32, 99);
        expect_word("R5 zero means 32", 32'hDEADBEEF, 32'h01234567, 0, 1);
        apply_reset(1'b1, 1'b1, 1'b1, 1'b0, 6'd40);
        go_idle();
        send_bits(32'hCAFEF00D, 32'h89ABCDEF, 32, 99);
        expect_word("R5 above 32 means 32", 32'hCAFEF00D, 32'h89ABCDEF, 0, 1);

        cur_req = "R6";
        apply_reset(1'b0, 1'b0, 1'b0, 1'b1, 6'd8);
        go_idle();
        send_bits(32'h3D, 32'hD3, 8, 99);
        expect_word("R6 active high asserted", 32'h3D, 32'hD3, 0, 1);
        send_bits(32'h11, 32'h22, 8, 0);
        expect_word("R6 active high idle", 32'h11, 32'h22, 1, 2);

        // R11: latency from pin change to strobe
        cur_req = "R11";
        apply_reset(1'b0, 1'b0, 1'b0, 1'b0, 6'd1);
        go_idle();
        set_cs(1'b1);
        bus_mosi = 1'b1; bus_miso = 1'b1;
        wait_cycles(2);
        bus_sclk = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 not after two edges", word_valid == 1'b0, word_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R11 strobe after three edges", word_valid == 1'b1 && word_mosi == 32'h1,
              {word_valid, word_mosi}, 33'h1_0000_0001);
        wait_cycles(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule